// File: doc/BRIEF.md
# Sub-page MMIO Area Dispatcher

This block sits in front of a single memory-mapped page and carves it into fixed 256-byte areas. An owner table, one entry per area, says which downstream device port receives accesses that land in that area. Each entry holds either a target number or an "unassigned" code. An upstream read or write is decoded against the page base. It is then steered to the owning port, together with its offset from the page base and its size code. An access that lands in an unassigned area finishes in the same cycle, reads as zero, and a write to it goes nowhere.

Software or a boot sequencer fills the owner table through a small configuration port. Each request names a byte range inside the page (start offset and length) and a target code. The table entry of every area touched by that range is overwritten, starting with the area that holds the first byte and ending with the area that holds the last byte. A range that would run past the end of the page is refused: an error flag rises and the table is not changed. The page base, page size, area size, data width and number of targets are parameters.

Top module: `mmio_subpage_dispatch`

## Requirements
- R1: The owning area of an access is ((address - page base) >> 8) modulo 16, and the access goes to the port recorded for that area.
- R2: A forwarded access carries the full address minus the page base as its offset (not the offset inside the area), and carries its write flag, write data and size code (0 byte, 1 halfword, 2 word) unchanged.
- R3: A configuration request with offset O and length L > 0 that is accepted overwrites the entries of areas O>>8 through (O+L-1)>>8 inclusive, and no others. Accesses in the cycle after the request see the new table.
- R4: A request with O + L greater than 4096 is refused. cfg_err is 1 in the cycle after it, and the table keeps its previous contents.
- R5: After reset every area is unassigned and cfg_err is 0.
- R6: An access to an unassigned area has up_ready 1 in the same cycle and up_rdata 0, and it raises no dn_valid bit, so a write to it is dropped.
- R7: An access to an assigned area raises exactly the dn_valid bit of its target. up_ready and up_rdata follow that target's dn_ready and read data.
- R8: A target code with bit 3 set (8 to 15) returns the covered areas to the unassigned state.
- R9: A request with L = 0 changes no entry and does not raise cfg_err.
- R10: Where ranges overlap, the entry holds the target of the latest accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_valid | input | 1 | Range assignment request, one cycle |
| cfg_off | input | 12 | Start offset of the range inside the page |
| cfg_len | input | 13 | Length of the range in bytes |
| cfg_tgt | input | 4 | Target number 0-7, or 8-15 to release |
| cfg_err | output | 1 | Previous request was refused |
| up_valid | input | 1 | Upstream access request |
| up_write | input | 1 | 1 write, 0 read |
| up_addr | input | 32 | Absolute access address |
| up_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| up_wdata | input | 32 | Write data |
| up_ready | output | 1 | Access completes this cycle |
| up_rdata | output | 32 | Read data |
| dn_valid | output | 8 | One request bit per target port |
| dn_write | output | 1 | Forwarded write flag |
| dn_offset | output | 32 | Address minus page base |
| dn_size | output | 2 | Forwarded size code |
| dn_wdata | output | 32 | Forwarded write data |
| dn_ready | input | 8 | Ready from each target port |
| dn_rdata | input | 256 | Read data, target t in bits t*32 +: 32 |

## Verification
The bench maps single-area, multi-area, overlapping and page-end ranges. It then probes the first and last byte of each affected area and the areas on either side. This shows whether the inclusive end rule and the index arithmetic are right, or whether the range is off by one area. Refused, zero-length and release requests are each followed by probes of the areas they could have touched, so that table corruption shows up at the ports. Byte, halfword and word reads and writes, with a target's ready held low, confirm that routing, offset and size forwarding are separate from the ready and read-data return path.

// File: rtl/mmio_disp_pkg.sv
package mmio_disp_pkg;
    // Fixed area granularity in address bits (256-byte areas).
    localparam int AREA_SHIFT_DEF = 8;
    // Page size in address bits (4 KB page).
    localparam int PAGE_BITS_DEF  = 12;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;
endpackage

// File: rtl/mmio_area_map.sv
module mmio_area_map #(
    parameter int PAGE_BITS = mmio_disp_pkg::PAGE_BITS_DEF,
    parameter int AREA_BITS = mmio_disp_pkg::AREA_SHIFT_DEF,
    parameter int TGT_W     = 4,
    localparam int NUM_AREAS  = 1 << (PAGE_BITS - AREA_BITS),
    localparam int IDX_W      = PAGE_BITS - AREA_BITS,
    localparam int PAGE_SIZE  = 1 << PAGE_BITS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_valid_i,
    input  logic [PAGE_BITS-1:0]             cfg_off_i,
    input  logic [PAGE_BITS:0]               cfg_len_i,
    input  logic [TGT_W-1:0]                 cfg_tgt_i,
    output logic                             cfg_err_o,
    output logic [NUM_AREAS-1:0][TGT_W-1:0]  map_o
);
    localparam logic [TGT_W-1:0] FREE_CODE = {1'b1, {(TGT_W-1){1'b0}}};

    typedef struct packed {
        logic [NUM_AREAS-1:0][TGT_W-1:0] map;
        logic                            err;
    } map_state_t;

    map_state_t s_d, s_q;

    logic [PAGE_BITS+1:0] end_excl;
    logic [PAGE_BITS+1:0] end_incl;
    logic                 too_long;
    logic                 len_zero;
    logic [IDX_W-1:0]     first_idx;
    logic [IDX_W-1:0]     last_idx;

    always_comb begin
        end_excl  = {2'b00, cfg_off_i} + {1'b0, cfg_len_i};
        end_incl  = end_excl - 1'b1;
        too_long  = end_excl > (PAGE_BITS+2)'(PAGE_SIZE);
        len_zero  = (cfg_len_i == '0);
        first_idx = IDX_W'(cfg_off_i >> AREA_BITS);
        last_idx  = IDX_W'(end_incl >> AREA_BITS);

        s_d     = s_q;
        s_d.err = 1'b0;
        if (cfg_valid_i) begin
            if (too_long) begin
                s_d.err = 1'b1;
            end else if (!len_zero) begin
                for (int a = 0; a < NUM_AREAS; a++) begin
                    if (IDX_W'(a) >= first_idx && IDX_W'(a) <= last_idx) begin
                        s_d.map[a] = cfg_tgt_i;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < NUM_AREAS; a++) begin
                s_q.map[a] <= FREE_CODE;
            end
            s_q.err <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_err_o = s_q.err;
    assign map_o     = s_q.map;

    // R4: an over-long range raises the error flag and leaves the table alone
    a_r4_refused_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_i && (({2'b00, cfg_off_i} + {1'b0, cfg_len_i}) > (PAGE_BITS+2)'(PAGE_SIZE)))
        |=> (cfg_err_o && $stable(map_o)));

    // R5: the error flag only follows a request
    a_r5_err_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> $past(cfg_valid_i));

    // R9: a zero-length range is a no-op
    a_r9_zero_len_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_i && cfg_len_i == '0) |=> ($stable(map_o) && !cfg_err_o));
endmodule

// File: rtl/mmio_route.sv
module mmio_route #(
    parameter int              ADDR_W    = 32,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] PAGE_BASE = 32'h4000_0000,
    parameter int              PAGE_BITS = mmio_disp_pkg::PAGE_BITS_DEF,
    parameter int              AREA_BITS = mmio_disp_pkg::AREA_SHIFT_DEF,
    parameter int              NUM_TGT   = 8,
    localparam int NUM_AREAS = 1 << (PAGE_BITS - AREA_BITS),
    localparam int IDX_W     = PAGE_BITS - AREA_BITS,
    localparam int TID_W     = $clog2(NUM_TGT),
    localparam int TGT_W     = TID_W + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_AREAS-1:0][TGT_W-1:0] map_i,
    input  logic                            up_valid_i,
    input  logic                            up_write_i,
    input  logic [ADDR_W-1:0]               up_addr_i,
    input  logic [1:0]                      up_size_i,
    input  logic [DATA_W-1:0]               up_wdata_i,
    output logic                            up_ready_o,
    output logic [DATA_W-1:0]               up_rdata_o,
    output logic [NUM_TGT-1:0]              dn_valid_o,
    output logic                            dn_write_o,
    output logic [ADDR_W-1:0]               dn_offset_o,
    output logic [1:0]                      dn_size_o,
    output logic [DATA_W-1:0]               dn_wdata_o,
    input  logic [NUM_TGT-1:0]              dn_ready_i,
    input  logic [NUM_TGT*DATA_W-1:0]       dn_rdata_i
);
    logic [ADDR_W-1:0] rel;
    logic [IDX_W-1:0]  area;
    logic [TGT_W-1:0]  owner;
    logic              is_free;
    logic [TID_W-1:0]  tid;

    always_comb begin
        rel     = up_addr_i - PAGE_BASE;
        area    = IDX_W'(rel >> AREA_BITS);
        owner   = map_i[area];
        is_free = owner[TGT_W-1];
        tid     = owner[TID_W-1:0];
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_port
        assign dn_valid_o[t] = up_valid_i && !is_free && (tid == TID_W'(t));
    end

    always_comb begin
        dn_write_o  = up_write_i;
        dn_offset_o = rel;
        dn_size_o   = up_size_i;
        dn_wdata_o  = up_wdata_i;
        if (is_free) begin
            up_ready_o = 1'b1;
            up_rdata_o = '0;
        end else begin
            up_ready_o = dn_ready_i[tid];
            up_rdata_o = up_valid_i ? dn_rdata_i[tid*DATA_W +: DATA_W] : '0;
        end
    end

    // R7: never more than one port requested
    a_r7_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_valid_o));

    // R7: completion follows the selected port's ready
    a_r7_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|dn_valid_o) |-> (up_ready_o == |(dn_valid_o & dn_ready_i)));

    // R6: unassigned area completes at once with zero and no downstream request
    a_r6_free_area: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid_i && map_i[area][TGT_W-1])
        |-> (up_ready_o && dn_valid_o == '0 && up_rdata_o == '0));
endmodule

// File: rtl/mmio_subpage_dispatch.sv
module mmio_subpage_dispatch #(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] PAGE_BASE = 32'h4000_0000,
    parameter int                PAGE_BITS = mmio_disp_pkg::PAGE_BITS_DEF,
    parameter int                AREA_BITS = mmio_disp_pkg::AREA_SHIFT_DEF,
    parameter int                NUM_TGT   = 8,
    localparam int NUM_AREAS = 1 << (PAGE_BITS - AREA_BITS),
    localparam int TGT_W     = $clog2(NUM_TGT) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_valid,
    input  logic [PAGE_BITS-1:0]      cfg_off,
    input  logic [PAGE_BITS:0]        cfg_len,
    input  logic [TGT_W-1:0]          cfg_tgt,
    output logic                      cfg_err,
    input  logic                      up_valid,
    input  logic                      up_write,
    input  logic [ADDR_W-1:0]         up_addr,
    input  logic [1:0]                up_size,
    input  logic [DATA_W-1:0]         up_wdata,
    output logic                      up_ready,
    output logic [DATA_W-1:0]         up_rdata,
    output logic [NUM_TGT-1:0]        dn_valid,
    output logic                      dn_write,
    output logic [ADDR_W-1:0]         dn_offset,
    output logic [1:0]                dn_size,
    output logic [DATA_W-1:0]         dn_wdata,
    input  logic [NUM_TGT-1:0]        dn_ready,
    input  logic [NUM_TGT*DATA_W-1:0] dn_rdata
);
    logic [NUM_AREAS-1:0][TGT_W-1:0] owner_map;

    mmio_area_map #(
        .PAGE_BITS (PAGE_BITS),
        .AREA_BITS (AREA_BITS),
        .TGT_W     (TGT_W)
    ) i_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_valid_i (cfg_valid),
        .cfg_off_i   (cfg_off),
        .cfg_len_i   (cfg_len),
        .cfg_tgt_i   (cfg_tgt),
        .cfg_err_o   (cfg_err),
        .map_o       (owner_map)
    );

    mmio_route #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PAGE_BASE (PAGE_BASE),
        .PAGE_BITS (PAGE_BITS),
        .AREA_BITS (AREA_BITS),
        .NUM_TGT   (NUM_TGT)
    ) i_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .map_i       (owner_map),
        .up_valid_i  (up_valid),
        .up_write_i  (up_write),
        .up_addr_i   (up_addr),
        .up_size_i   (up_size),
        .up_wdata_i  (up_wdata),
        .up_ready_o  (up_ready),
        .up_rdata_o  (up_rdata),
        .dn_valid_o  (dn_valid),
        .dn_write_o  (dn_write),
        .dn_offset_o (dn_offset),
        .dn_size_o   (dn_size),
        .dn_wdata_o  (dn_wdata),
        .dn_ready_i  (dn_ready),
        .dn_rdata_i  (dn_rdata)
    );
endmodule

// File: tb/test_mmio_subpage_dispatch.sv
module test_mmio_subpage_dispatch;
    localparam int          CLK_P = 10;
    localparam logic [31:0] BASE  = 32'h4000_0000;
    localparam int          FREE  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [11:0] cfg_off = '0;
    logic [12:0] cfg_len = '0;
    logic [3:0]  cfg_tgt = '0;
    logic        cfg_err;
    logic        up_valid = 1'b0;
    logic        up_write = 1'b0;
    logic [31:0] up_addr = '0;
    logic [1:0]  up_size = '0;
    logic [31:0] up_wdata = '0;
    logic        up_ready;
    logic [31:0] up_rdata;
    logic [7:0]  dn_valid;
    logic        dn_write;
    logic [31:0] dn_offset;
    logic [1:0]  dn_size;
    logic [31:0] dn_wdata;
    logic [7:0]  tb_rdy = 8'hFF;
    logic [255:0] dn_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int shadow [16];

    typedef struct {
        logic [31:0] rel;
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] wd;
        int          tgt;
    } exp_t;
    exp_t sb [$];

    function automatic logic [31:0] port_data(int t);
        return 32'hC0DE_0000 + 32'(t) * 32'h0101;
    endfunction

    for (genvar t = 0; t < 8; t++) begin : g_dev
        assign dn_rdata[t*32 +: 32] = port_data(t);
    end

    always #(CLK_P/2) clk = ~clk;

    mmio_subpage_dispatch #(
        .ADDR_W (32), .DATA_W (32), .PAGE_BASE (BASE),
        .PAGE_BITS (12), .AREA_BITS (8), .NUM_TGT (8)
    ) i_mmio_subpage_dispatch (
        .clk (clk), .rst_n (rst_n),
        .cfg_valid (cfg_valid), .cfg_off (cfg_off), .cfg_len (cfg_len),
        .cfg_tgt (cfg_tgt), .cfg_err (cfg_err),
        .up_valid (up_valid), .up_write (up_write), .up_addr (up_addr),
        .up_size (up_size), .up_wdata (up_wdata), .up_ready (up_ready),
        .up_rdata (up_rdata), .dn_valid (dn_valid), .dn_write (dn_write),
        .dn_offset (dn_offset), .dn_size (dn_size), .dn_wdata (dn_wdata),
        .dn_ready (tb_rdy), .dn_rdata (dn_rdata)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Configuration driver with its own model of the owner table.
    task automatic cfg(int off, int len, int tgt, string req);
        bit exp_err;
        @(posedge clk); #1;
        cfg_valid = 1'b1;
        cfg_off = 12'(off);
        cfg_len = 13'(len);
        cfg_tgt = 4'(tgt);
        @(posedge clk); #1;
        cfg_valid = 1'b0;
        exp_err = (off + len) > 4096;
        chk(cfg_err == exp_err, req, 32'(cfg_err), 32'(exp_err));
        if (!exp_err && len != 0) begin
            for (int a = off >> 8; a <= (off + len - 1) >> 8; a++) begin
                shadow[a] = (tgt >= 8) ? FREE : tgt;
            end
        end
    endtask

    // Access driver: pushes the expected result, monitor compares.
    task automatic access(int rel, bit wr, int sz, logic [31:0] wd);
        exp_t e;
        @(posedge clk); #1;
        e.rel = 32'(rel); e.wr = wr; e.sz = 2'(sz); e.wd = wd;
        e.tgt = shadow[(rel >> 8) & 15];
        sb.push_back(e);
        up_valid = 1'b1; up_write = wr; up_addr = BASE + 32'(rel);
        up_size = 2'(sz); up_wdata = wd;
        @(negedge clk); #1;
        up_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [7:0]  ev;
            logic        er;
            logic [31:0] ed;
            e  = sb.pop_front();
            ev = (e.tgt == FREE) ? 8'h00 : (8'h01 << e.tgt);
            er = (e.tgt == FREE) ? 1'b1 : tb_rdy[e.tgt];
            ed = (e.tgt == FREE) ? 32'h0 : port_data(e.tgt);
            if (e.tgt == FREE) begin
                chk(dn_valid == ev, "R6 dn_valid", 32'(dn_valid), 32'(ev));
                chk(up_ready == er, "R6 up_ready", 32'(up_ready), 32'(er));
                chk(up_rdata == ed, "R6 up_rdata", up_rdata, ed);
            end else begin
                chk(dn_valid == ev, "R1 dn_valid", 32'(dn_valid), 32'(ev));
                chk(up_ready == er, "R7 up_ready", 32'(up_ready), 32'(er));
                chk(up_rdata == ed, "R7 up_rdata", up_rdata, ed);
                chk(dn_offset == e.rel, "R2 dn_offset", dn_offset, e.rel);
                chk(dn_size == e.sz, "R2 dn_size", 32'(dn_size), 32'(e.sz));
                chk(dn_write == e.wr, "R2 dn_write", 32'(dn_write), 32'(e.wr));
                if (e.wr) chk(dn_wdata == e.wd, "R2 dn_wdata", dn_wdata, e.wd);
            end
        end
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 16; a++) shadow[a] = FREE;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R5: reset state
        chk(cfg_err == 1'b0, "R5 cfg_err after reset", 32'(cfg_err), 32'h0);
        for (int a = 0; a < 16; a++) access(a * 256 + 8, 1'b0, 2, 32'h0);
        access(12'h7F0, 1'b1, 0, 32'hDEAD_BEEF);      // R6 dropped write

        // R3: two-area range, probe edges and neighbours
        cfg(12'h100, 12'h200, 2, "R3 accept");
        access(12'h0FF, 1'b0, 0, 32'h0);
        access(12'h100, 1'b0, 2, 32'h0);
        access(12'h2FF, 1'b1, 0, 32'h1234_5678);
        access(12'h300, 1'b0, 2, 32'h0);

        // R3: unaligned range inside one area, then one straddling two
        cfg(12'h350, 12'h010, 5, "R3 accept small");
        access(12'h300, 1'b0, 1, 32'h0);
        access(12'h400, 1'b0, 1, 32'h0);
        cfg(12'h3F0, 12'h020, 6, "R10 accept overlap");
        access(12'h3FE, 1'b1, 1, 32'h0000_ABCD);      // R10 area 3 now 6
        access(12'h40F, 1'b0, 2, 32'h0);
        access(12'h500, 1'b0, 2, 32'h0);

        // R4: overflow by one byte refused, table unchanged
        cfg(12'hF00, 13'h101, 3, "R4 refused");
        access(12'hF00, 1'b0, 2, 32'h0);
        access(12'h100, 1'b0, 2, 32'h0);
        cfg(12'h000, 13'h1000, 4, "R4 full page ok");   // exact fit accepted
        access(12'h000, 1'b0, 2, 32'h0);
        access(12'hFFF, 1'b0, 0, 32'h0);

        // R8: release, then last area assigned at page end
        cfg(12'h000, 13'h1000, 8, "R8 release all");
        access(12'h800, 1'b1, 2, 32'hCAFE_0001);
        cfg(12'hF00, 13'h100, 7, "R3 last area");
        access(12'hEFF, 1'b0, 2, 32'h0);
        access(12'hFFC, 1'b0, 2, 32'h0);
        cfg(12'hF80, 13'h10, 12, "R8 partial release");
        access(12'hF00, 1'b0, 0, 32'h0);

        // R9: zero length changes nothing
        cfg(12'h500, 13'h0, 1, "R9 zero length");
        access(12'h500, 1'b0, 2, 32'h0);

        // R7: ready held low by the owning target, all size codes
        cfg(12'h600, 13'h100, 0, "R3 area6");
        tb_rdy = 8'hFE;
        access(12'h604, 1'b0, 0, 32'h0);
        access(12'h606, 1'b1, 1, 32'h0000_5A5A);
        access(12'h608, 1'b1, 2, 32'hA5A5_A5A5);
        tb_rdy = 8'hFF;
        access(12'h6FC, 1'b0, 2, 32'h0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule